// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses, on every clock, the control-memory address of the next microinstruction in a microprogrammed control unit. It looks at the branch-type and condition-select fields of the current microinstruction, at that microinstruction's address field, and at a few status inputs. From these it either steps to the following word, branches, calls a one-level subroutine, returns from it, or jumps to the start of the routine for the current instruction's opcode.

The block holds two registers: the control address register, which drives the control-memory address, and a single subroutine return register. A synchronous reset puts both at address 0, where the fetch routine begins. The control memory, the micro-operation fields and the datapath are outside the block. The status inputs come straight from the datapath: the instruction's opcode bits, its indirect bit, the accumulator sign bit and an accumulator-is-zero flag.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst` is high at a rising clock edge, `car` and `sbr` both become 0.
- R2: The condition is picked by `cond_sel`: 00 gives constant 1, 01 gives `ind_bit`, 10 gives `acc_sign`, 11 gives `acc_zero`.
- R3: Branch type 00 (jump): when the condition is 1, `car` loads `addr_fld`. When it is 0, `car` loads `car`+1. `sbr` is unchanged in both cases.
- R4: Branch type 01 (call): when the condition is 1, `sbr` loads `car`+1 and `car` loads `addr_fld`. When it is 0, `car` loads `car`+1 and `sbr` is unchanged.
- R5: Branch type 10 (return): `car` loads `sbr` whatever the condition, and `sbr` is unchanged.
- R6: Branch type 11 (map): `car` becomes `{1'b0, opcode, 2'b00}`, which is opcode times four. `sbr` is unchanged.
- R7: Address arithmetic is modulo 128. Adding one to 127 gives 0, both in `car` and in the return address that a call saves.
- R8: There is only one level of subroutine. A second call overwrites the saved return address, so a later return goes back to the address after the second call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition select field of the current microinstruction |
| br_type | input | 2 | Branch type field: 00 jump, 01 call, 10 return, 11 map |
| addr_fld | input | 7 | Address field of the current microinstruction |
| opcode | input | 4 | Opcode bits of the instruction in the data register |
| ind_bit | input | 1 | Indirect-address bit of the instruction |
| acc_sign | input | 1 | Accumulator sign bit |
| acc_zero | input | 1 | High when the accumulator is zero |
| car | output | 7 | Control address register |
| sbr | output | 7 | Subroutine return register |

## Verification
A taken call does two things in one cycle: it saves the incremented address into `sbr` and it loads `car` from the address field. A call issued at address 127 adds a third effect in that same cycle, because the saved return address wraps to 0. The bench provokes both cases on purpose, by jumping to 127 and then calling, and by issuing two calls in a row before a return. It judges each cycle against a bench model of both registers, so a wrong saved value shows up at the return that follows.

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int AW  = 7,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     cond_sel,
  input  logic [1:0]     br_type,
  input  logic [AW-1:0]  addr_fld,
  input  logic [OPW-1:0] opcode,
  input  logic           ind_bit,
  input  logic           acc_sign,
  input  logic           acc_zero,
  output logic [AW-1:0]  car,
  output logic [AW-1:0]  sbr
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  localparam int HI_ZEROS = AW - OPW - 2;

  logic          cond;
  logic [AW-1:0] car_inc;
  logic [AW-1:0] map_addr;
  logic [AW-1:0] car_nxt;
  logic [AW-1:0] sbr_nxt;

  always_comb begin
    case (cond_sel)
      2'b00:   cond = 1'b1;
      2'b01:   cond = ind_bit;
      2'b10:   cond = acc_sign;
      default: cond = acc_zero;
    endcase
  end

  assign car_inc  = car + ONE;
  assign map_addr = {{HI_ZEROS{1'b0}}, opcode, 2'b00};

  always_comb begin
    car_nxt = car_inc;
    sbr_nxt = sbr;
    case (br_type)
      2'b00: if (cond) car_nxt = addr_fld;
      2'b01: if (cond) begin
        car_nxt = addr_fld;
        sbr_nxt = car_inc;
      end
      2'b10: car_nxt = sbr;
      default: car_nxt = map_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= '0;
      sbr <= '0;
    end else begin
      car <= car_nxt;
      sbr <= sbr_nxt;
    end
  end
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int AW  = 7,
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     cond_sel,
  input logic [1:0]     br_type,
  input logic [AW-1:0]  addr_fld,
  input logic [OPW-1:0] opcode,
  input logic           ind_bit,
  input logic           acc_sign,
  input logic           acc_zero,
  input logic [AW-1:0]  car,
  input logic [AW-1:0]  sbr
);
  assert_reset_R1: assert property (@(posedge clk) rst |=> (car == '0 && sbr == '0));

  assert_jump_always_R3: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'b00 && cond_sel == 2'b00) |=> (car == $past(addr_fld) && sbr == $past(sbr)));

  assert_jump_notaken_R2: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'b00 && cond_sel == 2'b11 && !acc_zero) |=> car == $past(car) + 1'b1);

  assert_call_save_R4: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'b01 && cond_sel == 2'b10 && acc_sign) |=> (sbr == $past(car) + 1'b1 && car == $past(addr_fld)));

  assert_call_skip_R4: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'b01 && cond_sel == 2'b01 && !ind_bit) |=> $stable(sbr));

  assert_return_R5: assert property (@(posedge clk) disable iff (rst)
    br_type == 2'b10 |=> (car == $past(sbr) && $stable(sbr)));

  assert_map_R6: assert property (@(posedge clk) disable iff (rst)
    br_type == 2'b11 |=> (car[1:0] == 2'b00 && car[AW-1] == 1'b0 && car[OPW+1:2] == $past(opcode)));
endmodule

bind useq_next_addr useq_next_addr_chk #(.AW(AW), .OPW(OPW)) u_chk (.*);

// File: tb/useq_next_addr_test.sv
module useq_next_addr_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cond_sel, br_type;
  logic [6:0] addr_fld;
  logic [3:0] opcode;
  logic       ind_bit, acc_sign, acc_zero;
  logic [6:0] car, sbr;
  logic [6:0] m_car, m_sbr;
  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  useq_next_addr uut (.*);

  function automatic logic pick(input logic [1:0] cs, input logic i, input logic s, input logic z);
    return (cs == 2'b00) ? 1'b1 : (cs == 2'b01) ? i : (cs == 2'b10) ? s : z;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] cs, input logic [1:0] bt, input logic [6:0] ad,
                      input logic [3:0] op, input logic i, input logic s, input logic z);
    logic c;
    logic [6:0] nc, ns;
    string tag;
    cond_sel = cs; br_type = bt; addr_fld = ad; opcode = op;
    ind_bit = i; acc_sign = s; acc_zero = z;
    c = pick(cs, i, s, z);
    nc = m_car + 7'd1; ns = m_sbr;
    case (bt)
      2'b00: begin tag = "R3 jump"; if (c) nc = ad; end
      2'b01: begin tag = "R4 call"; if (c) begin nc = ad; ns = m_car + 7'd1; end end
      2'b10: begin tag = "R5 return"; nc = m_sbr; end
      default: begin tag = "R6 map"; nc = {1'b0, op, 2'b00}; end
    endcase
    @(posedge clk);
    @(negedge clk);
    check({tag, " car"}, car, nc);
    check({tag, " sbr"}, sbr, ns);
    m_car = nc; m_sbr = ns;
  endtask

  initial begin
    rst = 1'b1;
    cond_sel = 2'b00; br_type = 2'b00; addr_fld = 7'd55; opcode = 4'd0;
    ind_bit = 1'b0; acc_sign = 1'b0; acc_zero = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset car", car, 7'd0);
    check("R1 reset sbr", sbr, 7'd0);
    rst = 1'b0;
    m_car = 7'd0; m_sbr = 7'd0;

    step(2'b01, 2'b00, 7'd20, 4'd0, 1'b1, 1'b0, 1'b0);
    check("R2 indirect selects", car, 7'd20);
    step(2'b10, 2'b00, 7'd90, 4'd0, 1'b1, 1'b0, 1'b1);
    check("R2 sign not set", car, 7'd21);
    step(2'b11, 2'b00, 7'd33, 4'd0, 1'b0, 1'b0, 1'b1);
    check("R2 zero selects", car, 7'd33);
    step(2'b00, 2'b00, 7'd127, 4'd0, 1'b0, 1'b0, 1'b0);
    step(2'b01, 2'b00, 7'd9, 4'd0, 1'b0, 1'b1, 1'b1);
    check("R7 increment wraps", car, 7'd0);
    step(2'b00, 2'b00, 7'd127, 4'd0, 1'b0, 1'b0, 1'b0);
    step(2'b00, 2'b01, 7'd40, 4'd0, 1'b0, 1'b0, 1'b0);
    check("R7 call saves wrapped", sbr, 7'd0);
    step(2'b00, 2'b10, 7'd3, 4'd0, 1'b0, 1'b0, 1'b0);
    check("R7 return to wrapped", car, 7'd0);
    step(2'b00, 2'b00, 7'd10, 4'd0, 1'b0, 1'b0, 1'b0);
    step(2'b00, 2'b01, 7'd50, 4'd0, 1'b0, 1'b0, 1'b0);
    step(2'b00, 2'b01, 7'd70, 4'd0, 1'b0, 1'b0, 1'b0);
    check("R8 nested overwrites", sbr, 7'd51);
    step(2'b00, 2'b10, 7'd0, 4'd0, 1'b0, 1'b0, 1'b0);
    check("R8 return after nest", car, 7'd51);
    step(2'b01, 2'b01, 7'd99, 4'd0, 1'b0, 1'b1, 1'b1);
    check("R4 untaken keeps sbr", sbr, 7'd51);
    step(2'b00, 2'b11, 7'd0, 4'd15, 1'b0, 1'b0, 1'b0);
    check("R6 map opcode 15", car, 7'd60);
    step(2'b11, 2'b11, 7'd127, 4'd1, 1'b1, 1'b1, 1'b1);
    check("R6 map opcode 1", car, 7'd4);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[1:0], r[3:2], r[10:4], r[14:11], r[15], r[16], r[17]);
    end

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset mid-run car", car, 7'd0);
    check("R1 reset mid-run sbr", sbr, 7'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule